// File: doc/BRIEF.md
# Programmable I2C Clock Waveform Generator

This block produces the serial clock for an I2C-style bus master. It holds two byte-wide width settings, one for the clock-low phase and one for the clock-high phase. Each setting counts ticks of a fixed prescaler that divides the system clock by `TICK_DIV`. While the interface is enabled and a run request is present, the block alternates the clock between a pulled-low phase and a released phase. It always begins with a complete low phase.

Inside every low phase the block marks the data-hold point. This point lies a quarter of the programmed low width after the falling clock edge, and never less than one tick. The block raises `hold_done` for one cycle there. At that same moment it takes the data bit offered by the byte shifter and applies it to the open-drain data drive. The width settings can only be written while the interface is disabled. Disabling the interface or dropping the run request releases both lines and clears every counter.

The controller has three states:
- IDLE: both lines are released.
- LOW: the clock line is pulled low.
- HIGH: the clock line is released.

Its transitions are:
- IDLE→LOW (start): taken when enable and run are both high.
- LOW→HIGH (low-phase end): taken on the tick that completes the low width.
- HIGH→LOW (high-phase end): taken on the tick that completes the high width.
- any→IDLE (stop): taken when enable or run drops.

Top module: `scl_wavegen`

## Requirements
- R1: A low phase lasts max(WL,1) ticks, that is max(WL,1)*TICK_DIV clock cycles. WL is the low-width setting, and a value of 0 is treated as 1.
- R2: A high phase lasts max(WH,1)*TICK_DIV clock cycles. WH is the high-width setting, and a value of 0 is treated as 1.
- R3: After reset, both width settings hold 0xFF, so an unconfigured run gives 255-tick phases.
- R4: A write with `cfg_we`=1 replaces a whole byte. `cfg_sel`=0 selects the low width and `cfg_sel`=1 selects the high width. The write is accepted only while `if_enable`=0 and is ignored while `if_enable`=1.
- R5: `hold_done` pulses for exactly one cycle in each low phase. Counting the first low cycle as cycle 1, the pulse falls on cycle max(WL>>2,1)*TICK_DIV. When WL is 0 or 1, the pulse falls on the last cycle of the low phase.
- R6: `sda_pull_low` changes only on the clock edge that follows a `hold_done` cycle, where it takes the inverse of `tx_bit`. While idle it is 0.
- R7: When `if_enable` or `run_req` is 0, both pull-low outputs become 0 after the next clock edge and the counters are cleared. The first phase after a restart is a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Width register write strobe |
| cfg_sel | input | 1 | 0 selects the low width, 1 selects the high width |
| cfg_wdata | input | 8 | Width value to write |
| if_enable | input | 1 | Interface enable; also locks the width registers |
| run_req | input | 1 | Request to generate the clock |
| tx_bit | input | 1 | Data bit from the shifter, applied at the hold point |
| scl_pull_low | output | 1 | 1 drives the clock line low |
| sda_pull_low | output | 1 | 1 drives the data line low |
| hold_done | output | 1 | One-cycle strobe at the data-hold point |

## Verification
When the low width is 0 or 1, the hold delay equals the whole low phase. In that case the `hold_done` strobe and the LOW→HIGH transition fall in the same cycle. The stimulus table contains WL=0 and WL=1 rows to provoke this. For those rows the bench requires exactly one strobe in the phase, and it requires the strobe to land on the final low cycle, at the same offset as the measured low length. A dropped strobe or a doubled strobe shows up as a wrong count.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;
    localparam int WIDTH_BITS = 8;

    typedef logic [WIDTH_BITS-1:0] width_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // A zero width behaves as one tick.
    function automatic width_t eff_width(input width_t w);
        return (w == '0) ? width_t'(1) : w;
    endfunction

    // Data-hold delay: a quarter of the low width, at least one tick.
    function automatic width_t hold_ticks(input width_t w);
        width_t q;
        q = w >> 2;
        return (q == '0) ? width_t'(1) : q;
    endfunction
endpackage

// File: rtl/scl_width_regs.sv
module scl_width_regs
    import scl_wave_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   wr_sel,
    input  width_t wr_data,
    input  logic   lock,
    output width_t low_w,
    output width_t high_w
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_w  <= '1;
            high_w <= '1;
        end else if (wr_en && !lock) begin
            if (wr_sel) high_w <= wr_data;
            else        low_w  <= wr_data;
        end
    end

    // R4: no width changes while the interface is enabled
    assert_write_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(low_w) && $stable(high_w)));
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           cnt <= '0;
                else if (!run)        cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == LAST);

            // R1: ticks are separated by at least one idle cycle
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
    import scl_wave_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       if_enable,
    input  logic       run_req,
    input  logic       tx_bit,
    output logic       scl_pull_low,
    output logic       sda_pull_low,
    output logic       hold_done
);
    phase_e state, state_nx;
    width_t low_w, high_w;
    width_t ph_cnt, ph_lim, hold_lim, cnt_nx;
    logic   active, tick, phase_end;

    assign active = if_enable && run_req;
    assign cnt_nx = ph_cnt + width_t'(1);

    scl_width_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .lock    (if_enable),
        .low_w   (low_w),
        .high_w  (high_w)
    );

    scl_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != PH_IDLE),
        .tick  (tick)
    );

    assign phase_end = (state != PH_IDLE) && tick && (cnt_nx == ph_lim);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE: if (active)     state_nx = PH_LOW;
            PH_LOW:  if (!active)    state_nx = PH_IDLE;
                     else if (phase_end) state_nx = PH_HIGH;
            PH_HIGH: if (!active)    state_nx = PH_IDLE;
                     else if (phase_end) state_nx = PH_LOW;
            default:                 state_nx = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    // phase counter and widths latched at each phase start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt   <= '0;
            ph_lim   <= width_t'(1);
            hold_lim <= width_t'(1);
        end else if (state_nx == PH_IDLE) begin
            ph_cnt <= '0;
        end else if (state == PH_IDLE) begin
            ph_cnt   <= '0;
            ph_lim   <= eff_width(low_w);
            hold_lim <= hold_ticks(low_w);
        end else if (phase_end) begin
            ph_cnt <= '0;
            if (state == PH_LOW) begin
                ph_lim <= eff_width(high_w);
            end else begin
                ph_lim   <= eff_width(low_w);
                hold_lim <= hold_ticks(low_w);
            end
        end else if (tick) begin
            ph_cnt <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        scl_pull_low = (state == PH_LOW);
        hold_done    = (state == PH_LOW) && tick && (cnt_nx == hold_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sda_pull_low <= 1'b0;
        else if (!active)   sda_pull_low <= 1'b0;
        else if (hold_done) sda_pull_low <= ~tx_bit;
    end

    // R7: both lines released one edge after a stop
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!scl_pull_low && !sda_pull_low));

    // R1 / R2: the phase counter never reaches its limit
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |-> (ph_cnt < ph_lim));

    // R5: the hold point lies inside the latched low phase
    assert_hold_within_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> (hold_lim <= ph_lim));

    // R6: the data drive moves only after a hold strobe
    assert_sda_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !hold_done) |=> $stable(sda_pull_low));
endmodule

// File: tb/test_scl_wavegen.sv
module test_scl_wavegen;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       if_enable = 1'b0;
    logic       run_req = 1'b0;
    logic       tx_bit = 1'b1;
    logic       scl_pull_low, sda_pull_low, hold_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    scl_wavegen #(.TICK_DIV(DIV)) i_scl_wavegen (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .if_enable    (if_enable),
        .run_req      (run_req),
        .tx_bit       (tx_bit),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low),
        .hold_done    (hold_done)
    );

    always #4 clk = ~clk;

    // phase monitor, sampled on the falling edge
    int  lcnt = 0, hcnt = 0, hcount = 0;
    int  last_low = 0, last_high = 0, last_hold = 0, last_hcount = 0;
    bit  prev = 0;
    always @(negedge clk) begin
        if (scl_pull_low) begin
            if (!prev) begin
                last_high = hcnt;
                lcnt = 1;
                hcount = 0;
            end else begin
                lcnt++;
            end
            if (hold_done) begin
                last_hold = lcnt;
                hcount++;
            end
        end else begin
            if (prev) begin
                last_low = lcnt;
                last_hcount = hcount;
                hcnt = 1;
            end else begin
                hcnt++;
            end
        end
        prev = scl_pull_low;
    end

    // stimulus table: WL, WH, low cycles, high cycles, hold offset
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{  8,   5, 32,  20,  8},
        '{  0,   0,  4,   4,  4},
        '{  1,   1,  4,   4,  4},
        '{  3,   2, 12,   8,  4},
        '{ 20,   7, 80,  28, 20},
        '{ 13, 200, 52, 800, 12}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_low_start();
        do @(negedge clk); while (!scl_pull_low);
        #1;
    endtask

    task automatic wait_low_end();
        do @(negedge clk); while (scl_pull_low);
        #1;
    endtask

    task automatic stop_all();
        @(negedge clk);
        if_enable = 1'b0; run_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_run();
        @(negedge clk);
        if_enable = 1'b1; run_req = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R7: released after reset while idle
        chk("R7 scl idle after reset", scl_pull_low, 0);
        chk("R7 sda idle after reset", sda_pull_low, 0);
        chk("R5 no hold strobe idle", hold_done, 0);

        // R3: defaults 0xFF -> 255 ticks per phase
        start_run();
        wait_low_start();
        wait_low_end();
        chk("R3 default low length", last_low, 255 * DIV);
        wait_low_start();
        chk("R3 default high length", last_high, 255 * DIV);
        stop_all();

        // table walk: R1, R2, R5 and the full first low phase of R7
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, VEC[v][0]);
            wr(1'b1, VEC[v][1]);
            start_run();
            wait_low_start();
            wait_low_end();
            chk($sformatf("R1 R7 first low length vec%0d", v), last_low, VEC[v][2]);
            chk($sformatf("R5 hold offset vec%0d", v), last_hold, VEC[v][4]);
            chk($sformatf("R5 one strobe per low vec%0d", v), last_hcount, 1);
            wait_low_start();
            chk($sformatf("R2 high length vec%0d", v), last_high, VEC[v][3]);
            stop_all();
        end

        // R6: data drive follows hold strobe
        wr(1'b0, 8);
        wr(1'b1, 2);
        tx_bit = 1'b0;
        start_run();
        wait_low_start();
        chk("R6 sda released before hold", sda_pull_low, 0);
        do @(negedge clk); while (!hold_done);
        #1;
        chk("R6 sda unchanged in hold cycle", sda_pull_low, 0);
        @(negedge clk); #1;
        chk("R6 sda driven after hold", sda_pull_low, 1);
        tx_bit = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R6 sda held between strobes", sda_pull_low, 1);
        do @(negedge clk); while (!hold_done);
        @(negedge clk); #1;
        chk("R6 sda released at next hold", sda_pull_low, 0);

        // R7: stop mid low phase with data driven
        tx_bit = 1'b0;
        do @(negedge clk); while (!hold_done);
        @(negedge clk);
        run_req = 1'b0;
        @(negedge clk); #1;
        chk("R7 scl released on stop", scl_pull_low, 0);
        chk("R7 sda released on stop", sda_pull_low, 0);
        if_enable = 1'b0;
        tx_bit = 1'b1;
        repeat (2) @(negedge clk);

        // R4: writes ignored while enabled (settings stay WL=8, WH=2)
        if_enable = 1'b1;
        wr(1'b0, 40);
        wr(1'b1, 40);
        run_req = 1'b1;
        wait_low_start();
        wait_low_end();
        chk("R4 low width locked", last_low, 8 * DIV);
        wait_low_start();
        chk("R4 high width locked", last_high, 2 * DIV);
        stop_all();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule